// File: doc/BRIEF.md
# USB Host Pipe Status Controller

This block holds the live status of a single USB host pipe that moves data through two alternating packet banks. It keeps a ready flag for each bank, a freeze flag that stops the pipe, a pointer to the bank that serves the next packet and a data-toggle bit. Software cannot write these bits directly. It pulses a set strobe byte or a clear strobe byte, and each 1 in a strobe acts on the matching status bit. The packet engine reports bus events on single-cycle inputs, and each one adjusts the same bits.

Several bus events freeze the pipe on their own: a STALL handshake, the pipe-enable input going high, the end of an LPM transaction (whether it completed or timed out), and a transfer that ends with an error. A freeze that arrives while a bus transaction is running is held back. The freeze flag shows 1 only after the transaction has finished, so the transaction always completes. A control pipe uses bank 0 alone. A non-control pipe alternates between its two banks as packets complete.

Every update is registered. An input sampled at a clock edge shows on the outputs just after that edge.

Top module: `usb_pipe_status`

## Requirements
- R1: The status byte is laid out as bit 7 bank-1 ready, bit 6 bank-0 ready, bit 4 freeze, bit 2 current bank and bit 0 data toggle. Bits 5, 3 and 1 always read 0. After reset every bit is 0.
- R2: A 1 on bit 7 or bit 6 of the set strobe makes bank-1 or bank-0 ready 1. A 1 on the same bit of the clear strobe makes it 0. If both arrive in one cycle, the set wins. Strobe bits 5, 3, 2, 1 and 0 have no effect.
- R3: A 1 on bit 4 of the set strobe freezes the pipe. A 1 on bit 4 of the clear strobe unfreezes it. If both arrive in one cycle, the set wins.
- R4: A pulse on the STALL input freezes the pipe.
- R5: The pipe freezes on a 0-to-1 change of the pipe-enable input. Holding pipe-enable high does not freeze the pipe again after a clear.
- R6: A pulse on the LPM-done input or on the LPM-timeout input freezes the pipe.
- R7: A pulse on the transfer-error input freezes the pipe.
- R8: A freeze request (from the strobe or from any event) made while the transaction-busy input is 1 is held. The freeze bit becomes 1 only after the first clock edge at which the busy input is 0. A clear strobe that arrives during busy, with no new request in the same cycle, cancels a held request.
- R9: A hardware freeze event wins over a freeze clear strobe in the same cycle.
- R10: On a non-control pipe, a packet-done pulse clears the ready flag of the current bank, inverts the current-bank bit and inverts the data-toggle bit. A set strobe for that same bank in the same cycle wins over the clear.
- R11: On a control pipe, the bank-1 set strobe is ignored. A packet-done pulse clears bank-0 ready, forces the current bank to 0 and inverts the data-toggle bit.
- R12: The frozen output equals the freeze bit of the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isControl | input | 1 | 1 when the pipe is a control pipe |
| setStrobe | input | 8 | Write-one-to-set strobe, aligned to the status byte |
| clrStrobe | input | 8 | Write-one-to-clear strobe, aligned to the status byte |
| stallRcvd | input | 1 | STALL handshake received |
| pipeEnable | input | 1 | Pipe-enable level; a rise freezes the pipe |
| lpmDone | input | 1 | LPM transaction completed, whatever the handshake |
| lpmTimeout | input | 1 | LPM transaction timed out |
| xferError | input | 1 | Transfer completed with an error |
| txnBusy | input | 1 | A bus transaction is in progress on this pipe |
| packetDone | input | 1 | A packet on the current bank completed successfully |
| statusByte | output | 8 | Read-only pipe status |
| pipeFrozen | output | 1 | The pipe is frozen; no new requests may be issued |

## Verification
The bench goes after the deferred freeze. A design that froze at once would show the freeze bit while busy is still high. A design that lost the held request would never freeze once busy drops. A design that ignored a clear during busy would freeze when it should not. It also drives set and clear in the same cycle, and hardware events against software clears. A wrong priority there leaves a bank or the freeze bit 0 when it should be 1. Holding pipe-enable high after a clear catches a level-sensitive detector, because such a design freezes again at once. On a control pipe the bench leaves a stale bank-1 pointer in place and issues packet-done. A design that still alternated banks, or that accepted a bank-1 set, would show bit 2 or bit 7 set.

// File: rtl/usb_pipe_status_pkg.sv
package usb_pipe_status_pkg;

  localparam int STATUS_W  = 8;
  localparam int NUM_BANKS = 2;

  // Bit positions in the status byte and in both strobe bytes.
  localparam int BK1_POS = 7;
  localparam int BK0_POS = 6;
  localparam int FRZ_POS = 4;
  localparam int CUR_POS = 2;
  localparam int TGL_POS = 0;

  // Strobes from the control logic to the status register file.
  typedef struct packed {
    logic [NUM_BANKS-1:0] setBank;      // force bank ready to 1 (wins)
    logic [NUM_BANKS-1:0] clrBank;      // force bank ready to 0
    logic                 freezeNow;    // commit a freeze (wins)
    logic                 freezeClr;    // unfreeze
    logic                 bankAdvance;  // invert current bank
    logic                 bankHome;     // return current bank to 0
    logic                 toggleFlip;   // invert data toggle
  } pipeCtl_t;

endpackage

// File: rtl/usb_pipe_status_ctrl.sv
module usb_pipe_status_ctrl
  import usb_pipe_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                isControl,
  input  logic [STATUS_W-1:0] setStrobe,
  input  logic [STATUS_W-1:0] clrStrobe,
  input  logic                stallRcvd,
  input  logic                pipeEnable,
  input  logic                lpmDone,
  input  logic                lpmTimeout,
  input  logic                xferError,
  input  logic                txnBusy,
  input  logic                packetDone,
  input  logic                curBank,
  output pipeCtl_t            ctl
);

  logic prevEnable;
  logic freezePending;
  logic freezePendingNext;
  logic enableRise;
  logic hwFreezeEvent;
  logic freezeReq;
  logic [NUM_BANKS-1:0] bankDone;
  logic [NUM_BANKS-1:0] bankSetAllowed;

  // Strobe bits that this block does not act on.
  logic unusedStrobeBits;
  assign unusedStrobeBits = ^{setStrobe[5], setStrobe[3:0], clrStrobe[5], clrStrobe[3:0]};

  assign enableRise    = pipeEnable & ~prevEnable;
  assign hwFreezeEvent = stallRcvd | enableRise | lpmDone | lpmTimeout | xferError;
  assign freezeReq     = hwFreezeEvent | setStrobe[FRZ_POS];

  // A control pipe always completes on bank 0.
  always_comb begin
    bankDone[0] = packetDone & (isControl | ~curBank);
    bankDone[1] = packetDone & ~isControl & curBank;
  end

  // Bank 1 may only be made ready on a non-control pipe.
  assign bankSetAllowed = {~isControl, 1'b1};

  // Held-freeze bookkeeping: a request made during a busy bus
  // transaction waits for the transaction to end.
  always_comb begin
    if (freezeReq && txnBusy)
      freezePendingNext = 1'b1;
    else if (clrStrobe[FRZ_POS] || !txnBusy)
      freezePendingNext = 1'b0;
    else
      freezePendingNext = freezePending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEnable    <= 1'b0;
      freezePending <= 1'b0;
    end else begin
      prevEnable    <= pipeEnable;
      freezePending <= freezePendingNext;
    end
  end

  always_comb begin
    ctl.setBank[0]  = setStrobe[BK0_POS] & bankSetAllowed[0];
    ctl.setBank[1]  = setStrobe[BK1_POS] & bankSetAllowed[1];
    ctl.clrBank[0]  = clrStrobe[BK0_POS] | bankDone[0];
    ctl.clrBank[1]  = clrStrobe[BK1_POS] | bankDone[1];
    ctl.freezeNow   = (freezeReq | freezePending) & ~txnBusy;
    ctl.freezeClr   = clrStrobe[FRZ_POS];
    ctl.bankAdvance = packetDone & ~isControl;
    ctl.bankHome    = packetDone & isControl;
    ctl.toggleFlip  = packetDone;
  end

endmodule

// File: rtl/usb_pipe_status_dp.sv
module usb_pipe_status_dp
  import usb_pipe_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  pipeCtl_t            ctl,
  output logic [STATUS_W-1:0] statusByte,
  output logic                curBank,
  output logic                frozen
);

  localparam int BANK_POS_0 = BK0_POS;
  localparam int BANK_POS_1 = BK1_POS;

  logic [NUM_BANKS-1:0] bankReady;
  logic                 dataToggle;

  // One set-dominant flag per bank.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bankReady[b] <= 1'b0;
      else if (ctl.setBank[b])
        bankReady[b] <= 1'b1;
      else if (ctl.clrBank[b])
        bankReady[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      frozen <= 1'b0;
    else if (ctl.freezeNow)
      frozen <= 1'b1;
    else if (ctl.freezeClr)
      frozen <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      curBank <= 1'b0;
    else if (ctl.bankHome)
      curBank <= 1'b0;
    else if (ctl.bankAdvance)
      curBank <= ~curBank;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dataToggle <= 1'b0;
    else if (ctl.toggleFlip)
      dataToggle <= ~dataToggle;
  end

  always_comb begin
    statusByte             = '0;
    statusByte[BANK_POS_1] = bankReady[1];
    statusByte[BANK_POS_0] = bankReady[0];
    statusByte[FRZ_POS]    = frozen;
    statusByte[CUR_POS]    = curBank;
    statusByte[TGL_POS]    = dataToggle;
  end

endmodule

// File: rtl/usb_pipe_status.sv
module usb_pipe_status
  import usb_pipe_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                isControl,
  input  logic [STATUS_W-1:0] setStrobe,
  input  logic [STATUS_W-1:0] clrStrobe,
  input  logic                stallRcvd,
  input  logic                pipeEnable,
  input  logic                lpmDone,
  input  logic                lpmTimeout,
  input  logic                xferError,
  input  logic                txnBusy,
  input  logic                packetDone,
  output logic [STATUS_W-1:0] statusByte,
  output logic                pipeFrozen
);

  pipeCtl_t ctl;
  logic     curBank;

  usb_pipe_status_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .isControl  (isControl),
    .setStrobe  (setStrobe),
    .clrStrobe  (clrStrobe),
    .stallRcvd  (stallRcvd),
    .pipeEnable (pipeEnable),
    .lpmDone    (lpmDone),
    .lpmTimeout (lpmTimeout),
    .xferError  (xferError),
    .txnBusy    (txnBusy),
    .packetDone (packetDone),
    .curBank    (curBank),
    .ctl        (ctl)
  );

  usb_pipe_status_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .statusByte (statusByte),
    .curBank    (curBank),
    .frozen     (pipeFrozen)
  );

endmodule

// File: rtl/usb_pipe_status_checker.sv
module usb_pipe_status_checker
  import usb_pipe_status_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                isControl,
  input logic                stallRcvd,
  input logic                pipeEnable,
  input logic                lpmDone,
  input logic                lpmTimeout,
  input logic                xferError,
  input logic                txnBusy,
  input logic                packetDone,
  input logic [STATUS_W-1:0] statusByte
);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[5] == 1'b0) && (statusByte[3] == 1'b0) && (statusByte[1] == 1'b0));

  a_r4_stall_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (stallRcvd && !txnBusy) |=> statusByte[FRZ_POS]);

  a_r5_enable_rise_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (pipeEnable && !$past(pipeEnable) && !txnBusy) |=> statusByte[FRZ_POS]);

  a_r6_lpm_freezes: assert property (@(posedge clk) disable iff (!rstN)
    ((lpmDone || lpmTimeout) && !txnBusy) |=> statusByte[FRZ_POS]);

  a_r7_error_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (xferError && !txnBusy) |=> statusByte[FRZ_POS]);

  a_r8_no_freeze_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (txnBusy && !statusByte[FRZ_POS]) |=> !statusByte[FRZ_POS]);

  a_r10_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    packetDone |=> (statusByte[TGL_POS] != $past(statusByte[TGL_POS])));

  a_r11_control_bank1_idle: assert property (@(posedge clk) disable iff (!rstN)
    (isControl && !statusByte[BK1_POS]) |=> !statusByte[BK1_POS]);

endmodule

bind usb_pipe_status usb_pipe_status_checker i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .isControl  (isControl),
  .stallRcvd  (stallRcvd),
  .pipeEnable (pipeEnable),
  .lpmDone    (lpmDone),
  .lpmTimeout (lpmTimeout),
  .xferError  (xferError),
  .txnBusy    (txnBusy),
  .packetDone (packetDone),
  .statusByte (statusByte)
);

// File: tb/test_usb_pipe_status.sv
module test_usb_pipe_status;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       isControl = 1'b0;
  logic [7:0] setStrobe = '0;
  logic [7:0] clrStrobe = '0;
  logic       stallRcvd = 1'b0;
  logic       pipeEnable = 1'b0;
  logic       lpmDone = 1'b0;
  logic       lpmTimeout = 1'b0;
  logic       xferError = 1'b0;
  logic       txnBusy = 1'b0;
  logic       packetDone = 1'b0;
  logic [7:0] statusByte;
  logic       pipeFrozen;

  int checks = 0;
  int errors = 0;

  // Reference state
  int mBk0 = 0, mBk1 = 0, mFrz = 0, mCur = 0, mTgl = 0, mPend = 0, mPrevEn = 0;

  always #2 clk = ~clk;

  usb_pipe_status i_usb_pipe_status (
    .clk(clk), .rstN(rstN), .isControl(isControl),
    .setStrobe(setStrobe), .clrStrobe(clrStrobe),
    .stallRcvd(stallRcvd), .pipeEnable(pipeEnable),
    .lpmDone(lpmDone), .lpmTimeout(lpmTimeout),
    .xferError(xferError), .txnBusy(txnBusy),
    .packetDone(packetDone), .statusByte(statusByte),
    .pipeFrozen(pipeFrozen)
  );

  function automatic logic [7:0] expByte();
    logic [7:0] v;
    v = '0;
    v[7] = mBk1[0]; v[6] = mBk0[0]; v[4] = mFrz[0];
    v[2] = mCur[0]; v[0] = mTgl[0];
    return v;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (statusByte !== expByte()) begin
      errors++;
      $display("FAIL %s status actual %b expected %b", tag, statusByte, expByte());
    end
    checks++;
    if (pipeFrozen !== mFrz[0]) begin
      errors++;
      $display("FAIL R12 (%s) frozen actual %b expected %0d", tag, pipeFrozen, mFrz);
    end
  endtask

  // One clock: the model takes the inputs present at the edge.
  task automatic tick(input string tag);
    int req, rise, d0, d1, nb0, nb1, nf, np, nc, nt;
    @(posedge clk);
    rise = (pipeEnable && !mPrevEn) ? 1 : 0;
    req  = (setStrobe[4] || stallRcvd || rise || lpmDone || lpmTimeout || xferError) ? 1 : 0;
    if ((req || mPend) && !txnBusy) nf = 1;
    else if (clrStrobe[4]) nf = 0;
    else nf = mFrz;
    if (req && txnBusy) np = 1;
    else if (clrStrobe[4] || !txnBusy) np = 0;
    else np = mPend;
    d0 = (packetDone && (isControl || mCur == 0)) ? 1 : 0;
    d1 = (packetDone && !isControl && mCur == 1) ? 1 : 0;
    if (setStrobe[6]) nb0 = 1; else if (clrStrobe[6] || d0) nb0 = 0; else nb0 = mBk0;
    if (setStrobe[7] && !isControl) nb1 = 1; else if (clrStrobe[7] || d1) nb1 = 0; else nb1 = mBk1;
    nc = packetDone ? (isControl ? 0 : 1 - mCur) : mCur;
    nt = packetDone ? 1 - mTgl : mTgl;
    mBk0 = nb0; mBk1 = nb1; mFrz = nf; mPend = np; mCur = nc; mTgl = nt;
    mPrevEn = pipeEnable ? 1 : 0;
    #1;
    compare(tag);
  endtask

  task automatic quiet();
    setStrobe = '0; clrStrobe = '0; stallRcvd = 0; lpmDone = 0;
    lpmTimeout = 0; xferError = 0; packetDone = 0;
  endtask

  task automatic unfreeze(input string tag);
    quiet(); clrStrobe[4] = 1; tick(tag); quiet(); tick(tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    rstN = 1'b1;
    tick("R1");

    // R2 bank ready strobes
    setStrobe[6] = 1; tick("R2"); quiet();
    setStrobe[7] = 1; tick("R2"); quiet();
    clrStrobe[6] = 1; tick("R2"); quiet();
    setStrobe[7] = 1; clrStrobe[7] = 1; tick("R2 set wins"); quiet();
    setStrobe = 8'b0010_1111; tick("R2 ignored bits"); quiet();
    clrStrobe = 8'b0010_1111; tick("R2 ignored bits"); quiet();
    clrStrobe[7] = 1; tick("R2"); quiet();

    // R3 freeze strobes
    setStrobe[4] = 1; tick("R3"); quiet();
    clrStrobe[4] = 1; tick("R3"); quiet();
    setStrobe[4] = 1; clrStrobe[4] = 1; tick("R3 set wins"); quiet();
    unfreeze("R3");

    // R4, R6, R7 event freezes
    stallRcvd = 1; tick("R4"); unfreeze("R4");
    lpmDone = 1; tick("R6"); unfreeze("R6");
    lpmTimeout = 1; tick("R6"); unfreeze("R6");
    xferError = 1; tick("R7"); unfreeze("R7");

    // R5 rising edge only
    pipeEnable = 1; tick("R5"); quiet(); tick("R5");
    unfreeze("R5 level held");
    tick("R5 level held");
    pipeEnable = 0; tick("R5");

    // R8 deferred freeze
    txnBusy = 1; stallRcvd = 1; tick("R8"); quiet();
    tick("R8"); tick("R8");
    txnBusy = 0; tick("R8"); tick("R8");
    unfreeze("R8");
    txnBusy = 1; setStrobe[4] = 1; tick("R8"); quiet();
    clrStrobe[4] = 1; tick("R8 cancel"); quiet();
    txnBusy = 0; tick("R8 cancel"); tick("R8 cancel");

    // R9 event beats clear
    xferError = 1; clrStrobe[4] = 1; tick("R9"); quiet(); tick("R9");
    lpmTimeout = 1; clrStrobe[4] = 1; tick("R9"); quiet();
    unfreeze("R9");

    // R10 non-control ping-pong
    setStrobe[6] = 1; setStrobe[7] = 1; tick("R10"); quiet();
    packetDone = 1; tick("R10"); tick("R10"); quiet(); tick("R10");
    setStrobe[6] = 1; setStrobe[7] = 1; tick("R10"); quiet();
    packetDone = 1; setStrobe[6] = 1; tick("R10 set wins"); quiet();
    packetDone = 1; tick("R10"); quiet(); tick("R10");

    // R11 control pipe, leaving current bank at 1 first
    packetDone = 1; tick("R11 prep"); quiet();
    isControl = 1;
    setStrobe[7] = 1; setStrobe[6] = 1; tick("R11 bank1 ignored"); quiet();
    packetDone = 1; tick("R11"); quiet(); tick("R11");
    setStrobe[6] = 1; tick("R11"); quiet();
    packetDone = 1; tick("R11"); tick("R11"); quiet();
    setStrobe[7] = 1; tick("R11 bank1 ignored"); quiet(); tick("R11");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule